// File: doc/BRIEF.md
# PS/2 Device-Side Receiver with Acknowledge

This block is the host-to-device receive path of a PS/2 device controller. It sits idle and watches the open-drain clock and data lines. The host asks to send by holding the clock low and then letting it go while it keeps data low. The block then produces twelve clock pulses. It samples the start bit, eight data bits (least significant first), an odd parity bit and a stop bit. On the twelfth pulse it pulls data low to acknowledge.

A mode input decides how the acknowledge is sent. With the mode at 0, the block always acknowledges. With the mode at 1, it holds the acknowledge back when parity or the stop bit is wrong. An acknowledged byte moves into a single holding register. The byte's parity bit and a receive flag are updated at the same moment. Status outputs report busy, frame error and overwrite. The sticky flags are cleared by one-cycle strobes, and a read strobe marks the held byte as consumed.

Top module: `ps2d_rx`

## Requirements
- R1: A frame starts only when the synchronised clock line has been low and then returns high while the synchronised data line is low. Releasing the clock with data high starts nothing: no clock pulse is driven and `busy_o` stays 0.
- R2: A frame consists of exactly 12 clock pulses. Each pulse is `clk_drv_o`=1 (line pulled low) for HALF_CYC cycles, then 0 for HALF_CYC cycles. `busy_o` rises in the same cycle as the first pull and falls at the end of the twelfth high phase.
- R3: Each bit is sampled in the last cycle of a high phase. Pulse 1 carries the start bit. Pulses 2 to 9 carry data bit 0 to bit 7. Pulse 10 carries parity and pulse 11 carries the stop bit.
- R4: When the acknowledge is due, `dat_drv_o` is 1 for the whole of pulse 12, in both its low and high phases. `dat_drv_o` is 0 at all other times. With `ack_chk_i`=0 (the value taken at frame start), the acknowledge is always due.
- R5: With `ack_chk_i`=1, no acknowledge is driven if the count of ones in data plus parity is even, or if the stop bit is 0.
- R6: At the end of an acknowledged frame, `rx_data_o` takes the byte, `rx_parity_o` takes the received parity bit and `rx_flag_o` becomes 1. A frame without acknowledge changes none of the three.
- R7: A stop bit of 0 sets `frm_err_o` at the end of the frame in either mode. `frm_err_clr_i` clears it, and a set in the same cycle wins.
- R8: An acknowledged frame that completes while the previous byte is still unread sets `ovf_o`. `rd_i` marks the held byte read, and a read in the completion cycle counts for the old byte. `ovf_clr_i` clears `ovf_o`, and a set wins.
- R9: `rx_flag_clr_i` clears `rx_flag_o`, and a set in the same cycle wins.
- R10: After reset, all outputs are 0 and neither line is pulled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ps2_clk_i | input | 1 | PS/2 clock line level |
| ps2_dat_i | input | 1 | PS/2 data line level |
| ack_chk_i | input | 1 | 1: withhold acknowledge on parity or stop error |
| rd_i | input | 1 | Held byte has been read |
| frm_err_clr_i | input | 1 | Clear frame error flag |
| ovf_clr_i | input | 1 | Clear overwrite flag |
| rx_flag_clr_i | input | 1 | Clear receive flag |
| clk_drv_o | output | 1 | 1: pull clock line low |
| dat_drv_o | output | 1 | 1: pull data line low (acknowledge) |
| busy_o | output | 1 | Frame in progress |
| rx_data_o | output | 8 | Last acknowledged byte |
| rx_parity_o | output | 1 | Parity bit of that byte |
| rx_flag_o | output | 1 | Byte received |
| frm_err_o | output | 1 | Stop bit error seen |
| ovf_o | output | 1 | Unread byte was overwritten |

## Verification
Some properties are checked on every cycle. The line drives only move during a frame. A frame begins with the clock pulled. The held byte, the receive flag and the overwrite flag change only in the cycle right after an acknowledge was driven, and the frame error only appears as busy falls. Other behaviour shows up only through the bench's host scenarios. These include refusing a start with data high, sampling bits in order, odd-parity and stop-bit judgement in both modes, and pulse widths and count. They also cover the overwrite that follows a skipped read, against a cycle-by-cycle model fed with the bits the host drove.

// File: rtl/ps2d_rx_pkg.sv
package ps2d_rx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LO, ST_HI} phase_e;
  localparam int unsigned FRAME_PULSES = 12;
  localparam int unsigned SHIFT_BITS   = 10;  // data, parity, stop
  localparam int unsigned PAR_POS      = 8;
  localparam int unsigned STOP_POS     = 9;
endpackage

// File: rtl/ps2d_sync.sv
module ps2d_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] ff_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q[g] <= '1;
      else if (g == 0) ff_q[g] <= d_i;
      else ff_q[g] <= ff_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/ps2d_frame.sv
module ps2d_frame
  import ps2d_rx_pkg::*;
#(
  parameter int unsigned HALF_CYC = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clk_s_i,
  input  logic       dat_s_i,
  input  logic       ack_chk_i,
  output logic       clk_drv_o,
  output logic       dat_drv_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       ack_o,
  output logic [7:0] byte_o,
  output logic       par_o,
  output logic       stop_o
);
  localparam int unsigned CW = $clog2(HALF_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_CYC - 1);
  localparam logic [3:0] PN_LAST = 4'(FRAME_PULSES);

  phase_e               st_q;
  logic [CW-1:0]        cnt_q;
  logic [3:0]           pn_q;
  logic [SHIFT_BITS-1:0] sh_q;
  logic                 seen_low_q;
  logic                 chk_q;
  logic                 phase_end, frame_ok;

  assign phase_end = (cnt_q == CNT_LAST);
  assign frame_ok  = (^sh_q[PAR_POS:0]) & sh_q[STOP_POS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      pn_q       <= '0;
      sh_q       <= '0;
      seen_low_q <= 1'b0;
      chk_q      <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (seen_low_q && clk_s_i && !dat_s_i) begin
            st_q       <= ST_LO;
            cnt_q      <= '0;
            pn_q       <= 4'd1;
            seen_low_q <= 1'b0;
            chk_q      <= ack_chk_i;
          end else if (!clk_s_i) begin
            seen_low_q <= 1'b1;
          end else if (dat_s_i) begin
            seen_low_q <= 1'b0;  // released with data high: not a request
          end
        end
        ST_LO: begin
          if (phase_end) begin
            st_q  <= ST_HI;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_HI: begin
          if (phase_end) begin
            cnt_q <= '0;
            if (pn_q == PN_LAST) begin
              st_q <= ST_IDLE;
            end else begin
              if (pn_q != 4'd1) sh_q <= {dat_s_i, sh_q[SHIFT_BITS-1:1]};
              pn_q <= pn_q + 1'b1;
              st_q <= ST_LO;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ack_o     = !chk_q || frame_ok;
  assign busy_o    = (st_q != ST_IDLE);
  assign clk_drv_o = (st_q == ST_LO);
  assign dat_drv_o = busy_o && (pn_q == PN_LAST) && ack_o;
  assign done_o    = (st_q == ST_HI) && phase_end && (pn_q == PN_LAST);
  assign byte_o    = sh_q[7:0];
  assign par_o     = sh_q[PAR_POS];
  assign stop_o    = sh_q[STOP_POS];
endmodule

// File: rtl/ps2d_hold.sv
module ps2d_hold (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       done_i,
  input  logic       ack_i,
  input  logic [7:0] byte_i,
  input  logic       par_i,
  input  logic       stop_i,
  input  logic       rd_i,
  input  logic       frm_err_clr_i,
  input  logic       ovf_clr_i,
  input  logic       rx_flag_clr_i,
  output logic [7:0] rx_data_o,
  output logic       rx_parity_o,
  output logic       rx_flag_o,
  output logic       frm_err_o,
  output logic       ovf_o
);
  logic pend_q;
  logic take;

  assign take = done_i && ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_o   <= '0;
      rx_parity_o <= 1'b0;
      rx_flag_o   <= 1'b0;
      frm_err_o   <= 1'b0;
      ovf_o       <= 1'b0;
      pend_q      <= 1'b0;
    end else begin
      if (rd_i)          pend_q    <= 1'b0;
      if (frm_err_clr_i) frm_err_o <= 1'b0;
      if (ovf_clr_i)     ovf_o     <= 1'b0;
      if (rx_flag_clr_i) rx_flag_o <= 1'b0;
      if (take) begin
        rx_data_o   <= byte_i;
        rx_parity_o <= par_i;
        rx_flag_o   <= 1'b1;
        pend_q      <= 1'b1;
        if (pend_q && !rd_i) ovf_o <= 1'b1;
      end
      if (done_i && !stop_i) frm_err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/ps2d_rx.sv
module ps2d_rx #(
  parameter int unsigned HALF_CYC    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  input  logic       ack_chk_i,
  input  logic       rd_i,
  input  logic       frm_err_clr_i,
  input  logic       ovf_clr_i,
  input  logic       rx_flag_clr_i,
  output logic       clk_drv_o,
  output logic       dat_drv_o,
  output logic       busy_o,
  output logic [7:0] rx_data_o,
  output logic       rx_parity_o,
  output logic       rx_flag_o,
  output logic       frm_err_o,
  output logic       ovf_o
);
  logic [1:0] lines_s;
  logic       done, ack, par, stop;
  logic [7:0] byte_w;

  ps2d_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ps2_dat_i, ps2_clk_i}),
    .q_o   (lines_s)
  );

  ps2d_frame #(.HALF_CYC(HALF_CYC)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clk_s_i  (lines_s[0]),
    .dat_s_i  (lines_s[1]),
    .ack_chk_i(ack_chk_i),
    .clk_drv_o(clk_drv_o),
    .dat_drv_o(dat_drv_o),
    .busy_o   (busy_o),
    .done_o   (done),
    .ack_o    (ack),
    .byte_o   (byte_w),
    .par_o    (par),
    .stop_o   (stop)
  );

  ps2d_hold u_hold (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .done_i       (done),
    .ack_i        (ack),
    .byte_i       (byte_w),
    .par_i        (par),
    .stop_i       (stop),
    .rd_i         (rd_i),
    .frm_err_clr_i(frm_err_clr_i),
    .ovf_clr_i    (ovf_clr_i),
    .rx_flag_clr_i(rx_flag_clr_i),
    .rx_data_o    (rx_data_o),
    .rx_parity_o  (rx_parity_o),
    .rx_flag_o    (rx_flag_o),
    .frm_err_o    (frm_err_o),
    .ovf_o        (ovf_o)
  );
endmodule

// File: rtl/ps2d_rx_chk.sv
module ps2d_rx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       clk_drv_o,
  input logic       dat_drv_o,
  input logic       busy_o,
  input logic [7:0] rx_data_o,
  input logic       rx_flag_o,
  input logic       frm_err_o,
  input logic       ovf_o
);
  AST_CLK_ONLY_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_drv_o |-> busy_o); // R2
  AST_FRAME_OPENS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> clk_drv_o); // R2
  AST_ACK_ONLY_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_drv_o |-> busy_o); // R4
  AST_DATA_ONLY_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(dat_drv_o) |-> $stable(rx_data_o)); // R6
  AST_FLAG_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_flag_o) |-> $past(dat_drv_o)); // R6
  AST_OVF_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(dat_drv_o)); // R8
  AST_FERR_AT_FRAME_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frm_err_o) |-> ($past(busy_o) && !busy_o)); // R7
endmodule

bind ps2d_rx ps2d_rx_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clk_drv_o(clk_drv_o),
  .dat_drv_o(dat_drv_o),
  .busy_o   (busy_o),
  .rx_data_o(rx_data_o),
  .rx_flag_o(rx_flag_o),
  .frm_err_o(frm_err_o),
  .ovf_o    (ovf_o)
);

// File: tb/ps2d_rx_tb.sv
`timescale 1ns/1ps
module ps2d_rx_tb;
  localparam int HALF = 8;

  logic clk = 0, rst_n = 0;
  logic host_clk_low = 0, host_dat = 1;
  logic ack_chk = 0, rd = 0, fe_clr = 0, ov_clr = 0, fl_clr = 0;
  logic clk_drv, dat_drv, busy, rx_par, rx_flag, ferr, ovf;
  logic [7:0] rx_data;

  always #10 clk = ~clk;

  ps2d_rx #(.HALF_CYC(HALF), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ps2_clk_i(!(host_clk_low || clk_drv)),
    .ps2_dat_i(host_dat && !dat_drv),
    .ack_chk_i(ack_chk), .rd_i(rd), .frm_err_clr_i(fe_clr),
    .ovf_clr_i(ov_clr), .rx_flag_clr_i(fl_clr),
    .clk_drv_o(clk_drv), .dat_drv_o(dat_drv), .busy_o(busy),
    .rx_data_o(rx_data), .rx_parity_o(rx_par), .rx_flag_o(rx_flag),
    .frm_err_o(ferr), .ovf_o(ovf)
  );

  int n_tests = 0, n_fail = 0;
  bit done_run = 0;

  // reference model state
  bit       bits [12];
  bit       m_armed = 0, m_busy = 0, m_ack_on = 0, m_exp_ack = 0;
  int       m_pulse = 0, m_cd = 0, m_lo = 0, m_done = 0;
  logic [7:0] m_data = 0;
  bit       m_par = 0, m_flag = 0, m_ferr = 0, m_ovf = 0, m_pend = 0;
  bit       prev_drv = 0;
  bit       cap_rd = 0, cap_fe = 0, cap_ov = 0, cap_fl = 0;

  task automatic chk(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h @%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cap_rd = rd; cap_fe = fe_clr; cap_ov = ov_clr; cap_fl = fl_clr;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit p;
      p = m_pend;
      if (cap_rd) m_pend = 0;
      if (cap_fe) m_ferr = 0;
      if (cap_ov) m_ovf  = 0;
      if (cap_fl) m_flag = 0;
      if (m_cd > 0) begin
        m_cd--;
        if (m_cd == 0) begin
          chk("R2", "pulse count", m_pulse, 12);
          if (m_exp_ack) begin
            if (p && !cap_rd) m_ovf = 1;
            for (int i = 0; i < 8; i++) m_data[i] = bits[i+2];
            m_par = bits[10]; m_flag = 1; m_pend = 1;
          end
          if (!bits[11]) m_ferr = 1;
          m_busy = 0; m_ack_on = 0; m_pulse = 0; m_armed = 0;
          host_dat = 1; m_done++;
        end
      end
      if (clk_drv && !prev_drv) begin
        if (!m_armed) chk("R1", "clock without request", 1, 0);
        m_busy = 1; m_pulse++; m_lo = 0;
        if (m_pulse <= 11) host_dat = bits[m_pulse];
        if (m_pulse == 12) m_ack_on = m_exp_ack;
        if (m_pulse > 12) chk("R2", "extra pulse", m_pulse, 12);
      end
      if (clk_drv) m_lo++;
      if (!clk_drv && prev_drv) begin
        chk("R2", "low phase width", m_lo, HALF);
        if (m_pulse == 12) m_cd = HALF;
      end
      prev_drv = clk_drv;
      chk("R2", "busy", busy, m_busy);
      chk(ack_chk ? "R5" : "R4", "ack drive", dat_drv, m_ack_on);
      chk("R6", "rx_data", rx_data, m_data);
      chk("R6", "rx_parity", rx_par, m_par);
      chk("R9", "rx_flag", rx_flag, m_flag);
      chk("R7", "frm_err", ferr, m_ferr);
      chk("R8", "ovf", ovf, m_ovf);
    end
  end

  task automatic request(bit dat_low);
    @(negedge clk); host_clk_low = 1;
    repeat (6) @(negedge clk);
    if (dat_low) begin host_dat = 0; m_armed = 1; end
    repeat (4) @(negedge clk);
    host_clk_low = 0;
  endtask

  task automatic send(logic [7:0] b, bit par, bit stop, bit mode);
    int start;
    ack_chk = mode;
    bits[1] = 0;
    for (int i = 0; i < 8; i++) bits[i+2] = b[i];
    bits[10] = par; bits[11] = stop;
    m_exp_ack = !mode || (((^b) ^ par) && stop);
    start = m_done;
    request(1);
    while (m_done == start) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_strobe(ref logic s);
    @(negedge clk); s = 1; @(negedge clk); s = 0;
  endtask

  task automatic finish_run();
    if (!done_run) begin
      done_run = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10", "reset outputs",
        {clk_drv, dat_drv, busy, rx_data, rx_par, rx_flag, ferr, ovf}, 0);
    // R1: clock released with data high is not a request
    request(0);
    repeat (40) @(negedge clk);
    chk("R1", "no start on data high", busy, 0);
    // R3 R4 R6: good byte, mode 0
    send(8'hA5, 1'b1, 1'b1, 1'b0);
    chk("R3", "byte A5 order", rx_data, 8'hA5);
    chk("R6", "flag after ack", rx_flag, 1);
    // R8: unread byte overwritten
    send(8'h3C, 1'b1, 1'b1, 1'b0);
    chk("R8", "overwrite flagged", ovf, 1);
    chk("R3", "byte 3C", rx_data, 8'h3C);
    pulse_strobe(ov_clr);
    pulse_strobe(rd);
    @(negedge clk);
    chk("R8", "ovf cleared", ovf, 0);
    // read before next byte: no overwrite
    send(8'h01, 1'b0, 1'b1, 1'b0);
    chk("R8", "no overwrite after read", ovf, 0);
    chk("R6", "parity bit kept", rx_par, 0);
    pulse_strobe(rd);
    // R4: bad parity, mode 0 still acknowledged
    send(8'h80, 1'b1, 1'b1, 1'b0);
    chk("R4", "ack despite parity", rx_data, 8'h80);
    pulse_strobe(rd);
    pulse_strobe(fl_clr);
    @(negedge clk);
    chk("R9", "flag cleared", rx_flag, 0);
    // R5: bad parity, mode 1 withheld, nothing updated
    send(8'h5A, 1'b0, 1'b1, 1'b1);
    chk("R5", "data kept on bad parity", rx_data, 8'h80);
    chk("R5", "flag kept clear", rx_flag, 0);
    // R5 R7: bad stop, mode 1
    send(8'h7E, 1'b1, 1'b0, 1'b1);
    chk("R7", "frame error set", ferr, 1);
    chk("R5", "data kept on bad stop", rx_data, 8'h80);
    pulse_strobe(fe_clr);
    @(negedge clk);
    chk("R7", "frame error cleared", ferr, 0);
    // R7: bad stop, mode 0 acknowledged and flagged
    send(8'hC3, 1'b1, 1'b0, 1'b0);
    chk("R7", "frame error mode 0", ferr, 1);
    chk("R6", "byte C3", rx_data, 8'hC3);
    pulse_strobe(fe_clr);
    pulse_strobe(rd);
    // R5: good frame, mode 1 acknowledged
    send(8'hFF, 1'b1, 1'b1, 1'b1);
    chk("R5", "good frame mode 1", rx_data, 8'hFF);
    chk("R6", "flag mode 1", rx_flag, 1);
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule